// File: doc/BRIEF.md
# Zone Access State Map Table

This block keeps a footprint of recently touched memory zones. Memory is split into zones of a fixed number of cache lines (256 lines of 64 bytes, 16 KB, in the full-size setting). Each table entry holds one zone number as its tag, plus a 2-bit state for every line in that zone. The states record whether the line has been prefetched, demanded, or both. They never record the order of the accesses. A prefetch engine sitting next to the table uses these footprints for stride pattern matching.

Two kinds of update event arrive on one port: a demand access and a prefetch issue. Each event carries a line address. The table searches all entries for the zone at once. On a miss it takes the least recently updated entry, discards that entry's old footprint and installs the new zone. It then advances the addressed line's state. Line states only ever move forward.

A separate read port takes a line address. One cycle later it returns the footprints of that line's zone and of the zones directly below and above it. The full-size instance holds 52 entries, which the `ENTRIES` parameter sets. The defaults are smaller so that elaboration stays light.

Top module: `zmap_table`

## Requirements
- R1: After reset every entry is empty, `rd_valid` is low, and any read returns all-zero footprints.
- R2: A footprint holds 2 bits per line. Line j sits at bits [2j+1:2j]. The codes are 0 = untouched, 1 = prefetched, 2 = demanded, 3 = prefetched then demanded.
- R3: A demand event (`upd_prefetch` = 0) moves a line from 0 to 2 and from 1 to 3. It leaves codes 2 and 3 unchanged.
- R4: A prefetch event (`upd_prefetch` = 1) moves a line from 0 to 1 and leaves every other code unchanged.
- R5: While an entry keeps its zone, no line's code ever decreases.
- R6: An update to a zone with no entry installs that zone in the least recently updated entry. All its lines start at 0, and then the event is applied.
- R7: Every update, hit or miss, makes its entry the most recently updated. Reads do not change recency.
- R8: A read issued with `rd_en` in one cycle shows its result, with `rd_valid` high, after the next clock edge. The zone number is the line address shifted right by log2(`LINES`). The outputs are the footprints of zones z-1, z and z+1.
- R9: A zone with no entry reads as all zeros, and a read never allocates an entry. Below zone 0 and above the highest zone, the result reads as zeros; it does not wrap.
- R10: When a read and an update occur in the same cycle, the read returns the state from before that update.
- R11: No two valid entries ever hold the same zone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Update event present this cycle |
| upd_prefetch | input | 1 | 1 = prefetch issue, 0 = demand access |
| upd_line_addr | input | ADDR_W | Line address of the update event |
| rd_en | input | 1 | Read request |
| rd_line_addr | input | ADDR_W | Line address whose zone and neighbours are read |
| rd_valid | output | 1 | Read result valid |
| rd_map_below | output | 2*LINES | Footprint of zone z-1 |
| rd_map_center | output | 2*LINES | Footprint of zone z |
| rd_map_above | output | 2*LINES | Footprint of zone z+1 |

## Verification
The bench uses a four-entry table with eight lines per zone. It drives every demand and prefetch sequence of length one to three on separate lines. A transition table that lets a demanded line fall back, or lets a prefetch overwrite a demanded line, shows up as a wrong code. The recency checks fill the table, refresh the oldest zone and then force an eviction. A design that counts reads as uses, or that evicts by order of installation, throws out the wrong zone. The bench also reads at zone 0 and at the top zone, where a wrapping neighbour calculation would return the far end of the address space. A same-cycle read and update checks that the read returns the state from before the update. A long pseudo-random run then mixes evictions with edge zones.

// File: rtl/zmap_pkg.sv
package zmap_pkg;

  typedef enum logic [1:0] {
    LS_INIT = 2'd0,
    LS_PREF = 2'd1,
    LS_ACC  = 2'd2,
    LS_SUCC = 2'd3
  } line_state_e;

  typedef enum logic {
    EV_DEMAND   = 1'b0,
    EV_PREFETCH = 1'b1
  } event_e;

  // Forward-only line state step.
  function automatic line_state_e line_step(line_state_e cur, event_e ev);
    line_state_e nxt;
    case (cur)
      LS_INIT: nxt = (ev == EV_DEMAND) ? LS_ACC : LS_PREF;
      LS_PREF: nxt = (ev == EV_DEMAND) ? LS_SUCC : LS_PREF;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/zmap_cam.sv
module zmap_cam #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            ent_valid_i,
  input  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag_i,
  input  logic [TAG_W-1:0]              key_i,
  input  logic                          key_ok_i,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              hit_idx_o
);

  logic [ENTRIES-1:0] match;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      match[e] = key_ok_i && ent_valid_i[e] && (ent_tag_i[e] == key_i);
    end
  end

  always_comb begin
    hit_idx_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match[e]) hit_idx_o = IDX_W'(e);
    end
    hit_o = |match;
  end

endmodule

// File: rtl/zmap_lru.sv
module zmap_lru #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_o
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0][IDX_W-1:0] age_q, age_d;
  logic [ENTRIES-1:0]            oldest_vec;

  // Ages form a permutation of 0..ENTRIES-1; 0 is most recent.
  always_comb begin
    age_d = age_q;
    for (int e = 0; e < ENTRIES; e++) begin
      if (IDX_W'(e) == touch_idx_i) begin
        age_d[e] = '0;
      end else if (age_q[e] < age_q[touch_idx_i]) begin
        age_d[e] = age_q[e] + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) age_q[e] <= IDX_W'(e);
    end else if (touch_i) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    victim_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      oldest_vec[e] = (age_q[e] == OLDEST);
      if (oldest_vec[e]) victim_o = IDX_W'(e);
    end
  end

  // R7: exactly one entry is least recent at all times.
  a_r7_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest_vec));

  // R7: a touched entry becomes the most recent one.
  a_r7_touch_newest: assert property (@(posedge clk) disable iff (!rst_n)
    touch_i |=> (age_q[$past(touch_idx_i)] == '0));

endmodule

// File: rtl/zmap_entry.sv
module zmap_entry
  import zmap_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int TAG_W  = 20,
  localparam int LINE_W = $clog2(LINES),
  localparam int MAP_W  = 2 * LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              upd_i,
  input  event_e            ev_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [MAP_W-1:0]  map_o
);

  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q;
  logic [MAP_W-1:0] map_q, map_d;
  logic             map_we;
  int unsigned      nz_cnt;

  always_comb begin
    valid_d = valid_q | alloc_i;
    map_we  = alloc_i | upd_i;
    for (int j = 0; j < LINES; j++) begin
      line_state_e cur;
      cur = alloc_i ? LS_INIT : line_state_e'(map_q[2*j +: 2]);
      if (upd_i && (line_i == LINE_W'(j))) cur = line_step(cur, ev_i);
      map_d[2*j +: 2] = cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (alloc_i) tag_q <= tag_i;
    if (map_we)  map_q <= map_d;
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign map_o   = map_q;

  always_comb begin
    nz_cnt = 0;
    for (int j = 0; j < LINES; j++) begin
      if (map_q[2*j +: 2] != 2'd0) nz_cnt++;
    end
  end

  // R6: a fresh allocation leaves at most the addressed line touched.
  a_r6_alloc_clean: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> (nz_cnt <= 1));

  for (genvar j = 0; j < LINES; j++) begin : g_mono
    // R5: codes never step back while the zone stays resident.
    a_r5_no_backward: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && $past(valid_q) && !$past(alloc_i))
        |-> (map_q[2*j +: 2] >= $past(map_q[2*j +: 2])));
  end

endmodule

// File: rtl/zmap_table.sv
module zmap_table
  import zmap_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int LINES   = 64,
  parameter int ADDR_W  = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_valid,
  input  logic                 upd_prefetch,
  input  logic [ADDR_W-1:0]    upd_line_addr,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_line_addr,
  output logic                 rd_valid,
  output logic [2*LINES-1:0]   rd_map_below,
  output logic [2*LINES-1:0]   rd_map_center,
  output logic [2*LINES-1:0]   rd_map_above
);

  localparam int LINE_W = $clog2(LINES);
  localparam int ZONE_W = ADDR_W - LINE_W;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int MAP_W  = 2 * LINES;
  localparam int NPORT  = 3;

  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0][ZONE_W-1:0] ent_tag;
  logic [ENTRIES-1:0][MAP_W-1:0]  ent_map;

  // ---------------- update path ----------------
  logic [ZONE_W-1:0] upd_zone;
  logic [LINE_W-1:0] upd_line;
  logic              upd_hit;
  logic [IDX_W-1:0]  upd_hit_idx, victim, sel_idx;
  event_e            upd_ev;

  assign upd_zone = upd_line_addr[ADDR_W-1:LINE_W];
  assign upd_line = upd_line_addr[LINE_W-1:0];
  assign upd_ev   = upd_prefetch ? EV_PREFETCH : EV_DEMAND;

  zmap_cam #(.ENTRIES(ENTRIES), .TAG_W(ZONE_W)) u_upd_cam (
    .ent_valid_i (ent_valid),
    .ent_tag_i   (ent_tag),
    .key_i       (upd_zone),
    .key_ok_i    (1'b1),
    .hit_o       (upd_hit),
    .hit_idx_o   (upd_hit_idx)
  );

  zmap_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_i     (upd_valid),
    .touch_idx_i (sel_idx),
    .victim_o    (victim)
  );

  assign sel_idx = upd_hit ? upd_hit_idx : victim;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic alloc_e, upd_e;
    assign alloc_e = upd_valid && !upd_hit && (victim == IDX_W'(e));
    assign upd_e   = upd_valid && (sel_idx == IDX_W'(e));

    zmap_entry #(.LINES(LINES), .TAG_W(ZONE_W)) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc_i (alloc_e),
      .upd_i   (upd_e),
      .ev_i    (upd_ev),
      .line_i  (upd_line),
      .tag_i   (upd_zone),
      .valid_o (ent_valid[e]),
      .tag_o   (ent_tag[e]),
      .map_o   (ent_map[e])
    );
  end

  // ---------------- read path ----------------
  logic [ZONE_W-1:0]            rd_zone;
  logic [NPORT-1:0][ZONE_W-1:0] rd_key;
  logic [NPORT-1:0]             rd_key_ok;
  logic [NPORT-1:0][MAP_W-1:0]  rd_sel, rd_map_q;
  logic                         rd_valid_q;

  assign rd_zone      = rd_line_addr[ADDR_W-1:LINE_W];
  assign rd_key[0]    = rd_zone - ZONE_W'(1);
  assign rd_key_ok[0] = (rd_zone != '0);
  assign rd_key[1]    = rd_zone;
  assign rd_key_ok[1] = 1'b1;
  assign rd_key[2]    = rd_zone + ZONE_W'(1);
  assign rd_key_ok[2] = (rd_zone != '1);

  for (genvar k = 0; k < NPORT; k++) begin : g_rd
    logic             hit_k;
    logic [IDX_W-1:0] idx_k;

    zmap_cam #(.ENTRIES(ENTRIES), .TAG_W(ZONE_W)) u_rd_cam (
      .ent_valid_i (ent_valid),
      .ent_tag_i   (ent_tag),
      .key_i       (rd_key[k]),
      .key_ok_i    (rd_key_ok[k]),
      .hit_o       (hit_k),
      .hit_idx_o   (idx_k)
    );

    assign rd_sel[k] = hit_k ? ent_map[idx_k] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_map_q   <= '0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_map_q <= rd_sel;
    end
  end

  assign rd_valid      = rd_valid_q;
  assign rd_map_below  = rd_map_q[0];
  assign rd_map_center = rd_map_q[1];
  assign rd_map_above  = rd_map_q[2];

  // ---------------- checks ----------------
  logic dup_tag;
  always_comb begin
    dup_tag = 1'b0;
    for (int a = 0; a < ENTRIES; a++) begin
      for (int b = a + 1; b < ENTRIES; b++) begin
        if (ent_valid[a] && ent_valid[b] && (ent_tag[a] == ent_tag[b])) dup_tag = 1'b1;
      end
    end
  end

  // R11: zones are never resident twice.
  a_r11_unique_zone: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_tag);

  // R6: a missing zone lands in the entry that was least recent.
  a_r6_alloc_installs: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_hit)
      |=> (ent_valid[$past(victim)] && (ent_tag[$past(victim)] == $past(upd_zone))));

  // R9: a read alone never changes residency.
  a_r9_read_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !upd_valid) |=> $stable(ent_valid));

endmodule

// File: tb/tb_zmap_table.sv
`timescale 1ns/1ps
module tb_zmap_table;

  localparam int NE = 4;
  localparam int NL = 8;
  localparam int AW = 10;
  localparam int NZ = 1 << (AW - 3);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          upd_valid, upd_prefetch, rd_en;
  logic [AW-1:0] upd_line_addr, rd_line_addr;
  logic          rd_valid;
  logic [15:0]   rd_map_below, rd_map_center, rd_map_above;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  zmap_table #(.ENTRIES(NE), .LINES(NL), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_prefetch(upd_prefetch), .upd_line_addr(upd_line_addr),
    .rd_en(rd_en), .rd_line_addr(rd_line_addr),
    .rd_valid(rd_valid), .rd_map_below(rd_map_below),
    .rd_map_center(rd_map_center), .rd_map_above(rd_map_above)
  );

  // Reference state kept from the requirements.
  bit         mval [NE];
  int         mtag [NE];
  int         mage [NE];
  logic [1:0] mst  [NE][NL];

  function automatic void model_reset();
    for (int e = 0; e < NE; e++) begin
      mval[e] = 0; mtag[e] = -1; mage[e] = e;
      for (int l = 0; l < NL; l++) mst[e][l] = 2'd0;
    end
  endfunction

  function automatic void model_update(bit pf, int addr);
    int z, l, h, old;
    z = addr / NL; l = addr % NL; h = -1;
    for (int e = 0; e < NE; e++) if (mval[e] && mtag[e] == z) h = e;
    if (h < 0) begin
      for (int e = 0; e < NE; e++) if (mage[e] == NE - 1) h = e;
      mval[h] = 1; mtag[h] = z;
      for (int k = 0; k < NL; k++) mst[h][k] = 2'd0;
    end
    if (mst[h][l] == 2'd0)               mst[h][l] = pf ? 2'd1 : 2'd2;
    else if (mst[h][l] == 2'd1 && !pf)   mst[h][l] = 2'd3;
    old = mage[h];
    for (int e = 0; e < NE; e++) if (mage[e] < old) mage[e]++;
    mage[h] = 0;
  endfunction

  function automatic logic [15:0] mmap(int z);
    logic [15:0] m;
    m = '0;
    if (z >= 0 && z < NZ) begin
      for (int e = 0; e < NE; e++)
        if (mval[e] && mtag[e] == z)
          for (int l = 0; l < NL; l++) m[2*l +: 2] = mst[e][l];
    end
    return m;
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; upd_valid = 0; upd_prefetch = 0; rd_en = 0;
    upd_line_addr = '0; rd_line_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic upd(bit pf, int addr);
    @(negedge clk);
    upd_valid = 1; upd_prefetch = pf; upd_line_addr = AW'(addr);
    @(negedge clk);
    upd_valid = 0;
    model_update(pf, addr);
  endtask

  task automatic rd_check(int addr, string req);
    logic [15:0] el, ec, eh;
    int z;
    z = addr / NL;
    el = mmap(z - 1); ec = mmap(z); eh = mmap(z + 1);
    @(negedge clk);
    rd_en = 1; rd_line_addr = AW'(addr);
    @(negedge clk);
    rd_en = 0;
    check("R8", "rd_valid", {15'd0, rd_valid}, 16'd1);
    check(req, "below",  rd_map_below,  el);
    check(req, "center", rd_map_center, ec);
    check(req, "above",  rd_map_above,  eh);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    int zs [8];
    logic [15:0] prev;
    int line;

    // R1 reset state
    do_reset();
    check("R1", "rd_valid after reset", {15'd0, rd_valid}, 16'd0);
    rd_check(5 * NL + 1, "R1");
    @(negedge clk);
    check("R8", "rd_valid drops", {15'd0, rd_valid}, 16'd0);

    // R2 encoding with fixed constants
    upd(1, 40 * NL + 3);
    rd_check(40 * NL + 3, "R2 R4");
    check("R2", "prefetched line 3", rd_map_center, 16'h0040);
    upd(0, 40 * NL + 5);
    upd(0, 40 * NL + 3);
    rd_check(40 * NL, "R2 R3");
    check("R2", "demand codes", rd_map_center, 16'h08C0);

    // R3 R4 R5: every event sequence of length 1..3, one line each
    do_reset();
    line = 0;
    for (int len = 1; len <= 3; len++) begin
      for (int pat = 0; pat < (1 << len); pat++) begin
        int addr;
        addr = (20 + line / NL) * NL + (line % NL);
        prev = 16'd0;
        for (int s = 0; s < len; s++) begin
          logic [1:0] cur, old;
          upd(pat[s], addr);
          rd_check(addr, "R3 R4");
          cur = rd_map_center[2*(addr%NL) +: 2];
          old = prev[1:0];
          check("R5", "no step back", {14'd0, cur >= old}, 16'd1);
          prev = {14'd0, cur};
        end
        line++;
      end
    end

    // R6 R7 R9: recency and eviction
    do_reset();
    upd(0, 10 * NL); upd(0, 11 * NL); upd(0, 12 * NL); upd(0, 13 * NL);
    upd(0, 10 * NL);
    rd_check(10 * NL, "R3 R7");
    check("R3", "demand on demanded line", rd_map_center, 16'h0002);
    rd_check(50 * NL, "R9");
    check("R9", "absent zone", rd_map_center, 16'h0000);
    rd_check(11 * NL, "R7");
    upd(1, 14 * NL + 1);
    rd_check(11 * NL, "R6 R7");
    check("R7", "oldest zone evicted", rd_map_center, 16'h0000);
    rd_check(10 * NL, "R7");
    check("R7", "refreshed zone kept", rd_map_center, 16'h0002);
    upd(0, 11 * NL + 2);
    rd_check(11 * NL, "R6");
    check("R6", "reinstalled zone fresh", rd_map_center, 16'h0020);
    rd_check(12 * NL, "R6 R7");
    check("R6", "next oldest evicted", rd_map_center, 16'h0000);

    // R8 R9: neighbour reads at address-space edges
    do_reset();
    upd(1, 0 * NL + 7);
    upd(0, (NZ - 1) * NL);
    rd_check(0, "R9");
    check("R9", "below zone 0", rd_map_below, 16'h0000);
    check("R8", "zone 0 center", rd_map_center, 16'h4000);
    rd_check((NZ - 1) * NL + 4, "R9");
    check("R9", "above top zone", rd_map_above, 16'h0000);
    rd_check(1 * NL, "R8");
    check("R8", "zone 1 below", rd_map_below, 16'h4000);

    // R10: read and update in the same cycle
    @(negedge clk);
    upd_valid = 1; upd_prefetch = 0; upd_line_addr = AW'(30 * NL + 2);
    rd_en = 1; rd_line_addr = AW'(30 * NL + 2);
    @(negedge clk);
    upd_valid = 0; rd_en = 0;
    check("R10", "read before update", rd_map_center, 16'h0000);
    model_update(0, 30 * NL + 2);
    rd_check(30 * NL, "R10");
    check("R10", "update visible later", rd_map_center, 16'h0020);

    // Pseudo-random mix against the reference state
    zs = '{0, 1, 2, 3, 4, 5, NZ - 2, NZ - 1};
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      upd(lf[0], zs[lf[3:1]] * NL + int'(lf[6:4]));
      rd_check(zs[lf[9:7]] * NL + int'(lf[12:10]), "R3 R4 R6 R7 R9 R11");
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule